// File: doc/BRIEF.md
# Pseudo-Associative Cache with Way Prediction

A read cache that keeps the single-compare hit path of a direct-mapped array while cutting conflict misses. Storage is split into two halves. A line for a given index can sit in either half. Each set holds one prediction bit, and that bit names the half whose tag is compared first. A match there answers in one cycle. If the first compare fails, the other half is compared in the next cycle. A match there is a slow pseudo-hit. If both halves miss, the word is fetched from lower memory and written into the cache.

The CPU side issues a request with an address and waits on a ready signal. Each response carries the data and a two-bit hit-type code, which counts the fast hits, slow hits and misses for performance measurement. The lower-memory side holds a request and an address until one data beat comes back. Addresses are word addresses, and each line holds one word. The low address bits select the set, and the rest form the tag.

Top module: `pa_cache`

## Requirements
- R1: After reset (asynchronous, active low) `req_ready_o` is 1, `rsp_valid_o` and `mem_req_o` are 0, every line is invalid and every prediction bit points at half 0, so the first access to any address is a miss.
- R2: A request accepted (`req_valid_i` and `req_ready_o` high at a clock edge) that matches in the predicted half gives `rsp_valid_o` with `rsp_kind_o` = 2'b01 one cycle after acceptance. `req_ready_o` stays high, so back-to-back fast hits answer in consecutive cycles.
- R3: A request that misses in the predicted half and matches in the other half gives `rsp_kind_o` = 2'b10 two cycles after acceptance.
- R4: After a slow hit, the set's prediction bit points at the half that hit, so an immediate repeat of the same address is a fast hit.
- R5: On a miss in both halves, `mem_req_o` rises two cycles after acceptance with `mem_addr_o` equal to the request address. Both stay unchanged until `mem_valid_i`. The response follows one cycle after `mem_valid_i` with `rsp_kind_o` = 2'b11 and `rsp_data_o` = `mem_data_i`.
- R6: A refilled word is written into the half that was not predicted, and the prediction bit is set to that half. A repeat access is then a fast hit, and the line already in the other half is still present as a slow hit.
- R7: `req_ready_o` is 0 from the cycle after a non-fast acceptance until the response. A request presented while it is 0 is ignored and leaves neither cache contents nor the memory request changed.
- R8: With two lines resident in a set, a miss to a third tag evicts the line in the half that was not predicted, and a later access to the evicted tag misses.
- R9: The data of every hit equals the word that the refill wrote for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU request present |
| req_addr_i | input | ADDR_W | CPU word address |
| req_ready_o | output | 1 | Cache can accept a request this cycle |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_data_o | output | DATA_W | Response data |
| rsp_kind_o | output | 2 | Hit type: 01 fast, 10 slow, 11 miss |
| mem_req_o | output | 1 | Refill request to lower memory |
| mem_addr_o | output | ADDR_W | Refill word address |
| mem_valid_i | input | 1 | Refill data beat present |
| mem_data_i | input | DATA_W | Refill data |

## Verification
The assertions assume that lower memory raises `mem_valid_i` only while `mem_req_o` is high, for a single cycle per request. The stimulus meets this with a responder that waits a fixed number of cycles after seeing a refill request, pulses the data once and drops it when the request falls. The CPU-side stimulus may drive requests while `req_ready_o` is low, because the design must ignore them. Conflict sequences on one set drive every transition of the prediction bit and every replacement choice.

// File: rtl/pa_cache_pkg.sv
package pa_cache_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_FAST = 2'd1,
    KIND_SLOW = 2'd2,
    KIND_MISS = 2'd3
  } hit_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ALT  = 2'd1,
    ST_FILL = 2'd2
  } probe_state_e;
endpackage

// File: rtl/pa_way_store.sv
module pa_way_store #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/pa_pred_table.sv
module pa_pred_table #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_bit_o,
  input  logic             set_en_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             set_val_i
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else if (set_en_i) bits_q[set_idx_i] <= set_val_i;
  end

  assign rd_bit_o = bits_q[rd_idx_i];

  // R4/R6: every update moves the bit to the other half
  a_r6_pred_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |-> set_val_i != bits_q[set_idx_i]);
endmodule

// File: rtl/pa_probe_ctrl.sv
module pa_probe_ctrl
  import pa_cache_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_valid_i,
  input  logic         hit_pred_i,
  input  logic         hit_alt_i,
  input  logic         mem_valid_i,
  output probe_state_e state_o,
  output logic         ready_o,
  output logic         capture_o,
  output logic         mem_req_o,
  output logic         rsp_load_o,
  output logic         fill_o,
  output logic         pred_upd_o,
  output logic         rsp_valid_o,
  output hit_kind_e    rsp_kind_o
);
  probe_state_e state_q, state_d;
  hit_kind_e    kind_d, kind_q;
  logic         rsp_valid_q;

  always_comb begin
    state_d    = state_q;
    kind_d     = KIND_NONE;
    rsp_load_o = 1'b0;
    fill_o     = 1'b0;
    pred_upd_o = 1'b0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        capture_o = 1'b1;
        if (hit_pred_i) begin
          rsp_load_o = 1'b1;
          kind_d     = KIND_FAST;
        end else begin
          state_d = ST_ALT;
        end
      end
      ST_ALT: begin
        if (hit_alt_i) begin
          rsp_load_o = 1'b1;
          kind_d     = KIND_SLOW;
          pred_upd_o = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_FILL: if (mem_valid_i) begin
        rsp_load_o = 1'b1;
        kind_d     = KIND_MISS;
        fill_o     = 1'b1;
        pred_upd_o = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      kind_q      <= KIND_NONE;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_load_o;
      kind_q      <= kind_d;
    end
  end

  assign state_o     = state_q;
  assign ready_o     = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_FILL);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_kind_o  = kind_q;

  a_r2_fast_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == KIND_FAST) |-> $past(req_valid_i && ready_o));

  a_r3_slow_follows_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == KIND_SLOW) |-> $past(state_q == ST_ALT));

  a_r5_miss_follows_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == KIND_MISS) |-> $past(mem_valid_i && mem_req_o));

  a_r5_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> mem_req_o);

  a_r2_kind_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_kind_o != KIND_NONE);

  a_r7_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> !$past(capture_o));
endmodule

// File: rtl/pa_cache.sv
module pa_cache
  import pa_cache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [1:0]        rsp_kind_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam int TAG_W = ADDR_W - IDX_W;

  probe_state_e state;
  hit_kind_e    kind;
  logic capture, rsp_load, fill, pred_upd, pred_bit, alt_half;
  logic hit_pred, hit_alt;
  logic [ADDR_W-1:0] addr_q, cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [DATA_W-1:0] rsp_data_q, data_sel;

  logic [1:0]        way_valid, way_hit;
  logic [TAG_W-1:0]  way_tag  [2];
  logic [DATA_W-1:0] way_data [2];

  assign cur_addr = (state == ST_IDLE) ? req_addr_i : addr_q;
  assign cur_idx  = cur_addr[IDX_W-1:0];
  assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
  assign alt_half = ~pred_bit;

  for (genvar h = 0; h < 2; h++) begin : g_half
    pa_way_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_idx_i  (cur_idx),
      .rd_valid_o(way_valid[h]),
      .rd_tag_o  (way_tag[h]),
      .rd_data_o (way_data[h]),
      .wr_en_i   (fill && (alt_half == 1'(h))),
      .wr_idx_i  (cur_idx),
      .wr_tag_i  (cur_tag),
      .wr_data_i (mem_data_i)
    );
    assign way_hit[h] = way_valid[h] && (way_tag[h] == cur_tag);
  end

  assign hit_pred = way_hit[pred_bit];
  assign hit_alt  = way_hit[alt_half];

  pa_pred_table #(.IDX_W(IDX_W)) u_pred (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (cur_idx),
    .rd_bit_o (pred_bit),
    .set_en_i (pred_upd),
    .set_idx_i(cur_idx),
    .set_val_i(alt_half)
  );

  pa_probe_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .hit_pred_i (hit_pred),
    .hit_alt_i  (hit_alt),
    .mem_valid_i(mem_valid_i),
    .state_o    (state),
    .ready_o    (req_ready_o),
    .capture_o  (capture),
    .mem_req_o  (mem_req_o),
    .rsp_load_o (rsp_load),
    .fill_o     (fill),
    .pred_upd_o (pred_upd),
    .rsp_valid_o(rsp_valid_o),
    .rsp_kind_o (kind)
  );

  always_comb begin
    unique case (state)
      ST_ALT:  data_sel = way_data[alt_half];
      ST_FILL: data_sel = mem_data_i;
      default: data_sel = way_data[pred_bit];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      rsp_data_q <= '0;
    end else begin
      if (capture)  addr_q     <= req_addr_i;
      if (rsp_load) rsp_data_q <= data_sel;
    end
  end

  assign rsp_data_o = rsp_data_q;
  assign rsp_kind_o = kind;
  assign mem_addr_o = addr_q;

  a_r5_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> $stable(mem_addr_o));

  a_r6_one_half_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(way_hit[0] && way_hit[1]));
endmodule

// File: tb/sim_pa_cache.sv
`timescale 1ns/1ps
module sim_pa_cache;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam logic [1:0] K_FAST = 2'b01, K_SLOW = 2'b10, K_MISS = 2'b11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic req_ready_o, rsp_valid_o, mem_req_o;
  logic [DATA_W-1:0] rsp_data_o;
  logic [1:0] rsp_kind_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic mem_valid_i = 1'b0;
  logic [DATA_W-1:0] mem_data_i = '0;

  int n_checks = 0;
  int n_err = 0;
  logic [ADDR_W-1:0] last_mem_addr = '0;

  always #2.5 clk = ~clk;

  pa_cache u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_ready_o(req_ready_o),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .rsp_kind_o(rsp_kind_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i)
  );

  function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return {4'hD, a} ^ 16'h3C5A;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // lower memory: data beat on the third sampled cycle of a request
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_req_o && !mem_valid_i) begin
        cnt++;
        if (cnt == 3) begin
          mem_valid_i   = 1'b1;
          mem_data_i    = word_of(mem_addr_o);
          last_mem_addr = mem_addr_o;
        end
      end else begin
        mem_valid_i = 1'b0;
        cnt = 0;
      end
    end
  end

  task automatic access(input logic [ADDR_W-1:0] a, input logic [1:0] exp_kind,
                        input bit inject, input logic [ADDR_W-1:0] inj);
    int lat;
    bit busy_ok;
    int exp_lat;
    string rq;
    @(negedge clk);
    check(req_ready_o == 1'b1, "R7", "ready before request", req_ready_o, 1);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    lat = 1;
    busy_ok = 1'b1;
    while (!rsp_valid_o && lat < 40) begin
      if (req_ready_o) busy_ok = 1'b0;
      if (inject && lat == 1) begin req_valid_i = 1'b1; req_addr_i = inj; end
      if (inject && lat == 3) req_valid_i = 1'b0;
      @(negedge clk);
      lat++;
    end
    exp_lat = (exp_kind == K_FAST) ? 1 : (exp_kind == K_SLOW) ? 2 : 5;
    rq = (exp_kind == K_FAST) ? "R2" : (exp_kind == K_SLOW) ? "R3" : "R5";
    check(rsp_kind_o == exp_kind, rq, "hit kind", rsp_kind_o, exp_kind);
    check(lat == exp_lat, rq, "latency", lat, exp_lat);
    check(rsp_data_o == word_of(a), "R9", "data", rsp_data_o, word_of(a));
    check(busy_ok, "R7", "ready low while busy", busy_ok, 1);
    if (exp_kind == K_MISS)
      check(last_mem_addr == a, "R5", "refill address", last_mem_addr, a);
  endtask

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [1:0]        kind;
  } vec_t;

  // set 3 conflict walk: tags 01 (A), 02 (B), 03 (C); set 5: D
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{12'h013, 2'b11},  // R1 cold miss, A into half 1
    '{12'h013, 2'b01},  // R6
    '{12'h023, 2'b11},  // B into half 0
    '{12'h023, 2'b01},
    '{12'h013, 2'b10},  // R3 / R6 A kept
    '{12'h013, 2'b01},  // R4
    '{12'h023, 2'b10},
    '{12'h023, 2'b01},  // R4
    '{12'h033, 2'b11},  // R8 C evicts A
    '{12'h033, 2'b01},
    '{12'h023, 2'b10},
    '{12'h013, 2'b11},  // R8 A evicted, evicts C
    '{12'h045, 2'b11},
    '{12'h045, 2'b01},
    '{12'h033, 2'b11},  // R8 C evicts B
    '{12'h013, 2'b10}
  };

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready_o == 1'b1, "R1", "ready in reset", req_ready_o, 1);
    check(rsp_valid_o == 1'b0, "R1", "rsp_valid in reset", rsp_valid_o, 0);
    check(mem_req_o == 1'b0, "R1", "mem_req in reset", mem_req_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) access(VEC[i].addr, VEC[i].kind, 1'b0, '0);

    // R7: request during a refill is ignored
    access(12'h0A7, K_MISS, 1'b1, 12'h0B7);
    access(12'h0B7, K_MISS, 1'b0, '0);   // R7 not filled by ignored request
    access(12'h0A7, K_SLOW, 1'b0, '0);
    access(12'h0A7, K_FAST, 1'b0, '0);

    // R2: back-to-back fast hits
    @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = 12'h0A7;
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid_o && rsp_kind_o == K_FAST, "R2", "first back-to-back", rsp_kind_o, K_FAST);
    check(req_ready_o == 1'b1, "R2", "ready stays high", req_ready_o, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    check(rsp_valid_o && rsp_kind_o == K_FAST, "R2", "second back-to-back", rsp_kind_o, K_FAST);
    check(rsp_data_o == word_of(12'h0A7), "R9", "back-to-back data", rsp_data_o, word_of(12'h0A7));

    // R1: reset mid-run clears lines and predictors
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(req_ready_o == 1'b1, "R1", "ready after reset", req_ready_o, 1);
    check(rsp_valid_o == 1'b0, "R1", "rsp_valid after reset", rsp_valid_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    access(12'h0A7, K_MISS, 1'b0, '0);   // R1 lines invalid
    access(12'h0A7, K_FAST, 1'b0, '0);   // R1 predictor back at half 0: fill went to half 1

    summary();
    $finish;
  end
endmodule